// File: doc/BRIEF.md
# Registered Adder/Subtractor Calculator

This block is a small arithmetic unit with two operand registers. Both registers take their value from one shared data bus. Each register has its own load strobe, so software or a controlling sequencer can write the first operand, then the second, or both at once. The stored operands drive a ripple-carry adder. A plain mode pin selects between summing the operands and subtracting the second operand from the first.

Subtraction uses two's complement. A per-bit two-way selector passes either the true or the complemented second operand to the adder. The same mode bit feeds the adder's carry input. The result word and the carry-out are continuous combinational functions of the two registers and the mode pin. They need no handshake and are valid in every cycle. The data path has no back-pressure: a load strobe is always accepted on the clock edge where it is high.

Top module: `calc_addsub`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both operand registers are cleared to 0. After that, `result` is 0 and `carry_out` equals `sub_mode`.
- R2: `load_a` high at a rising edge stores `din` into operand A. With `load_a` low, A keeps its value whatever `din` does.
- R3: `load_b` high at a rising edge stores `din` into operand B. With `load_b` low, B keeps its value whatever `din` does.
- R4: When `load_a` and `load_b` are both high in the same cycle, both registers capture the same `din` value.
- R5: Reset takes priority over any load in the same cycle. Both registers end at 0.
- R6: With `sub_mode`=0 (add), `result` is (A+B) mod 2^W and `carry_out` is bit W of A+B. For example, 5+6 gives 11 with carry 0, 6+3 gives 9, and 9+8 gives 1 with carry 1.
- R7: With `sub_mode`=1 (subtract), `result` is (A-B) mod 2^W. `carry_out` is 1 when A>=B unsigned (no borrow) and 0 when a borrow occurs. For example, 3-5 gives 14 with carry 0.
- R8: A change on `sub_mode` changes `result` and `carry_out` in the same cycle, without any clock edge.
- R9: `sub_mode` never alters the stored operands. After switching to subtract and back to add, the sum is the same as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both registers |
| rst_n | input | 1 | Synchronous active-low clear of both registers |
| din | input | W (4) | Shared operand data bus |
| load_a | input | 1 | Write strobe for operand A |
| load_b | input | 1 | Write strobe for operand B |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | W (4) | Sum or difference, modulo 2^W |
| carry_out | output | 1 | Adder carry out; in subtract mode 1 means no borrow |

## Verification
Two sets of events can land on the same clock edge. The first is a reset together with one or both load strobes. The bench drives `rst_n` low with both strobes high and `din` at all ones, then judges the outcome from the outputs: a zero result, and a carry that follows the mode pin. The second is both strobes together, which is judged by A+A and A-A giving the expected values. An exhaustive sweep over every operand pair in both modes checks the arithmetic.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int unsigned CALC_WIDTH = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } calc_op_e;
endpackage

// File: rtl/calc_operand_reg.sv
module calc_operand_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/calc_bsel.sv
module calc_bsel #(
  parameter int unsigned W = 4
) (
  input  calc_pkg::calc_op_e op,
  input  logic [W-1:0]       b_true,
  output logic [W-1:0]       b_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_out[i] = (op == calc_pkg::OP_SUB) ? ~b_true[i] : b_true[i];
  end
endmodule

// File: rtl/calc_ripple_adder.sv
module calc_ripple_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = a[i] ^ b[i];
    assign sum[i]   = p ^ c[i];
    assign c[i+1]   = (a[i] & b[i]) | (p & c[i]);
  end

  assign cout = c[W];
endmodule

// File: rtl/calc_addsub.sv
module calc_addsub #(
  parameter int unsigned W = calc_pkg::CALC_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         load_a,
  input  logic         load_b,
  input  logic         sub_mode,
  output logic [W-1:0] result,
  output logic         carry_out
);
  import calc_pkg::*;

  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] b_sel;
  calc_op_e     op;

  assign op = calc_op_e'(sub_mode);

  calc_operand_reg #(.W(W)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .load(load_a), .d(din), .q(opnd_a)
  );

  calc_operand_reg #(.W(W)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .load(load_b), .d(din), .q(opnd_b)
  );

  calc_bsel #(.W(W)) u_bsel (
    .op(op), .b_true(opnd_b), .b_out(b_sel)
  );

  calc_ripple_adder #(.W(W)) u_adder (
    .a(opnd_a), .b(b_sel), .cin(op == OP_SUB),
    .sum(result), .cout(carry_out)
  );
endmodule

// File: rtl/calc_addsub_chk.sv
module calc_addsub_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] din,
  input logic         load_a,
  input logic         load_b,
  input logic         sub_mode,
  input logic [W-1:0] result,
  input logic         carry_out
);
  logic [W-1:0] sh_a, sh_b;
  logic         seen_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; seen_rst <= 1'b1;
    end else begin
      if (load_a) sh_a <= din;
      if (load_b) sh_b <= din;
    end
  end

  logic [W:0] exp_add, exp_sub;
  assign exp_add = {1'b0, sh_a} + {1'b0, sh_b};
  assign exp_sub = {1'b0, sh_a} + {1'b0, ~sh_b} + {{W{1'b0}}, 1'b1};

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (result == '0 && carry_out == sub_mode));

  p_add_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rst && !sub_mode) |-> ({carry_out, result} == exp_add));

  p_sub_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rst && sub_mode) |-> ({carry_out, result} == exp_sub));

  p_borrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rst && sub_mode) |-> (carry_out == (sh_a >= sh_b)));

  p_hold_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rst && !load_a && !load_b) |=>
      (sub_mode != $past(sub_mode) || !$past(rst_n) || $stable(result)));
endmodule

bind calc_addsub calc_addsub_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .load_a(load_a), .load_b(load_b),
  .sub_mode(sub_mode), .result(result), .carry_out(carry_out)
);

// File: tb/tb_calc_addsub.sv
module tb_calc_addsub;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         load_a = 1'b0, load_b = 1'b0, sub_mode = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  calc_addsub #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .load_a(load_a), .load_b(load_b),
    .sub_mode(sub_mode), .result(result), .carry_out(carry_out)
  );

  task automatic check(string req, int got_r, int got_c, int exp_r, int exp_c);
    n_cmp++;
    if (got_r != exp_r || got_c != exp_c) begin
      n_bad++;
      $display("FAIL %s: result=%0d carry=%0d expected result=%0d carry=%0d",
               req, got_r, got_c, exp_r, exp_c);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(bit to_a, bit to_b, int v);
    din = v[W-1:0]; load_a = to_a; load_b = to_b;
    tick();
    load_a = 0; load_b = 0;
  endtask

  task automatic expect_now(string req, int a, int b, bit sub);
    int e;
    sub_mode = sub;
    #1;
    if (!sub) e = a + b;
    else      e = a + ((~b) & 15) + 1;
    check(req, result, carry_out, e & 15, (e >> 4) & 1);
  endtask

  // R1, R5: reset with both loads pending
  task automatic t_reset_vs_load();
    @(negedge clk);
    rst_n = 0; din = 4'hF; load_a = 1; load_b = 1;
    tick();
    load_a = 0; load_b = 0; rst_n = 1;
    expect_now("R1_R5 add", 0, 0, 0);
    expect_now("R1_R5 sub", 0, 0, 1);
  endtask

  // R2, R3, R6: independent loads and hold
  task automatic t_loads_and_hold();
    load(1, 0, 5); load(0, 1, 6);
    expect_now("R6 5+6", 5, 6, 0);
    load(1, 0, 6); load(0, 1, 3);
    expect_now("R6 6+3", 6, 3, 0);
    din = 4'hC; tick(); tick();
    expect_now("R2_R3 hold", 6, 3, 0);
    load(1, 0, 2);
    expect_now("R2 A only", 2, 3, 0);
    load(0, 1, 9);
    expect_now("R3 B only", 2, 9, 0);
  endtask

  // R4: both strobes together
  task automatic t_both_loads();
    load(1, 1, 7);
    expect_now("R4 add", 7, 7, 0);
    expect_now("R4 sub", 7, 7, 1);
  endtask

  // R6, R7 boundary values
  task automatic t_boundaries();
    load(1, 0, 9); load(0, 1, 8);
    expect_now("R6 overflow", 9, 8, 0);
    load(1, 1, 15);
    expect_now("R6 max", 15, 15, 0);
    load(1, 0, 3); load(0, 1, 5);
    expect_now("R7 borrow", 3, 5, 1);
    load(1, 0, 9); load(0, 1, 4);
    expect_now("R7 no borrow", 9, 4, 1);
    load(1, 1, 0);
    expect_now("R7 zero", 0, 0, 1);
  endtask

  // R8, R9: live mode switch, registers untouched
  task automatic t_mode_switch();
    load(1, 0, 12); load(0, 1, 10);
    expect_now("R8 add", 12, 10, 0);
    expect_now("R8 sub", 12, 10, 1);
    tick();
    expect_now("R9 back to add", 12, 10, 0);
  endtask

  // R6, R7 sweep
  task automatic t_sweep();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        load(1, 0, a); load(0, 1, b);
        expect_now("R6 sweep", a, b, 0);
        expect_now("R7 sweep", a, b, 1);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1; tick();
    t_reset_vs_load();
    t_loads_and_hold();
    t_both_loads();
    t_boundaries();
    t_mode_switch();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: result=%0d carry=%0d expected finish", result, carry_out);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule